// File: doc/BRIEF.md
# Extended Bank Register Mapper

This block sits on the cartridge side of an 8-bit CPU bus and translates addresses for two fetch paths. The CPU writes to the upper half of its address space to program a control register, a set of bank registers and a mirroring mode. From those registers the block produces the upper address bits for two streams. One is the bank number behind each of four 8 KB program windows. The other is the bank number behind each of eight 1 KB pattern windows seen by the picture unit.

Unlike the common arrangement, all four program windows have their own bank register. The odd pattern banks can also be loaded on their own instead of always following their even neighbour. Two control bits reorder the program windows and swap the two 4 KB pattern halves. A build parameter selects pattern RAM, in which case pattern bank numbers wrap modulo 8. The bank outputs are combinational from the registers and the incoming address, so a new mapping is visible from the cycle after the write.

Top module: `xbank_mapper`

## Requirements
- R1: A write is decoded only from address bits 15, 14, 13 and 0, and only when bit 15 is 1. With bits 14:13 = 00, an even address loads the control register and an odd address loads the bank register chosen by the index. With bits 14:13 = 01, an even address loads the mirroring mode. Every other write address changes no output.
- R2: The index is control bits 3:0. A data write with index 0 loads pattern bank 0 with the data and pattern bank 1 with data+1 modulo 256. Index 1 does the same for pattern banks 2 and 3.
- R3: Indices 2 to 5 load pattern banks 4 to 7. Indices 6 to 9 load program banks 0 to 3, keeping the low log2(PRG_BANKS) data bits. Index 0xA loads pattern bank 1 alone and index 0xB loads pattern bank 3 alone.
- R4: A data write with index 0xC to 0xF changes no bank output.
- R5: Program window w is selected by address bits 14:13. With control bit 6 clear, windows 0..3 show program banks 0,1,2,3. With it set, they show banks 2,1,0,3.
- R6: Pattern window w is selected by picture address bits 12:10. With control bit 7 clear, window w shows pattern bank w. With it set, it shows pattern bank w XOR 4.
- R7: The mirroring output takes the low two data bits of a mirroring write: 0 vertical, 1 horizontal, 2 single-screen low, 3 single-screen high.
- R8: After reset, the control register and the mirroring mode are 0. Program banks are 0, 1, PRG_BANKS-2 and PRG_BANKS-1, and pattern banks are 0 to 7.
- R9: With CHR_RAM set, each pattern bank output keeps only its low 3 bits, and the upper bits are 0.
- R10: A write captured at a clock edge is not visible before that edge and is visible right after it. The outputs follow address changes with no clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; writes are captured on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| cpuWrite | input | 1 | Write strobe, sampled at the rising edge |
| ppuAddr | input | 14 | Picture unit address |
| prgBank | output | log2(PRG_BANKS) | Program bank for the window addressed by cpuAddr |
| chrBank | output | CHR_W | Pattern bank for the window addressed by ppuAddr |
| mirrorMode | output | 2 | Nametable mirroring mode |

## Verification
On every cycle, the assertions check the following. At most one write strobe is raised, and never without the write input. An ignored index leaves all bank registers unchanged. Index 0 leaves pattern bank 1 one above pattern bank 0. The mirroring mode changes only after a mirroring write. The top program window always shows bank 3, and the outputs hold whenever their inputs hold. The following are shown only by the bench's scenarios: the full index-to-bank mapping, the reset values, the effect of both control bits on every window, the alias addresses that must decode, the addresses that must be ignored, and the modulo-8 wrap of the pattern RAM variant.

// File: rtl/xbank_pkg.sv
package xbank_pkg;

  localparam int DATA_W = 8;

  // Write strobes handed from the bus decoder to the register file.
  typedef struct packed {
    logic              ctrlWr;
    logic              dataWr;
    logic              mirrWr;
    logic [DATA_W-1:0] wdata;
  } wrStrobe_t;

  typedef enum logic [1:0] {
    MIR_VERT   = 2'd0,
    MIR_HORZ   = 2'd1,
    MIR_ONE_LO = 2'd2,
    MIR_ONE_HI = 2'd3
  } mirror_e;

  // Register index codes carried in control bits 3:0.
  localparam logic [3:0] IDX_CPAIR0 = 4'h0;
  localparam logic [3:0] IDX_CPAIR1 = 4'h1;
  localparam logic [3:0] IDX_CODD1  = 4'hA;
  localparam logic [3:0] IDX_CODD3  = 4'hB;

endpackage

// File: rtl/xbank_decode.sv
module xbank_decode
  import xbank_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        addrTop,   // address bits 15:13
  input  logic              addrLsb,   // address bit 0
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrEn,
  output wrStrobe_t         strb
);

  logic [3:0] sel;
  assign sel = {addrTop, addrLsb};

  always_comb begin
    strb        = '0;
    strb.wdata  = wrData;
    if (wrEn) begin
      unique case (sel)
        4'b1000: strb.ctrlWr = 1'b1;
        4'b1001: strb.dataWr = 1'b1;
        4'b1010: strb.mirrWr = 1'b1;
        default: ;
      endcase
    end
  end

  // R1: a single strobe at a time
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.ctrlWr, strb.dataWr, strb.mirrWr}));

  // R1: no strobe without a bus write in the upper half
  a_r1_need_write: assert property (@(posedge clk) disable iff (rst)
    (!wrEn || !addrTop[2]) |-> !(strb.ctrlWr || strb.dataWr || strb.mirrWr));

endmodule

// File: rtl/xbank_regs.sv
module xbank_regs
  import xbank_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_W     = 8,
  localparam int PRG_BW   = $clog2(PRG_BANKS)
)(
  input  logic                  clk,
  input  logic                  rst,
  input  wrStrobe_t             strb,
  output logic                  prgSwap,
  output logic                  chrSwap,
  output logic [3:0][PRG_BW-1:0] prgRegs,
  output logic [7:0][CHR_W-1:0]  chrRegs,
  output mirror_e               mirror
);

  localparam logic [PRG_BW-1:0] PRG_LAST = PRG_BW'(PRG_BANKS - 1);
  localparam logic [PRG_BW-1:0] PRG_PREV = PRG_BW'(PRG_BANKS - 2);

  logic [3:0]       ctrlIdx;
  logic [CHR_W-1:0] chrVal;
  logic [CHR_W-1:0] chrNext;

  assign chrVal  = CHR_W'(strb.wdata);
  assign chrNext = chrVal + CHR_W'(1);

  // control register
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlIdx <= '0;
      prgSwap <= 1'b0;
      chrSwap <= 1'b0;
    end else if (strb.ctrlWr) begin
      ctrlIdx <= strb.wdata[3:0];
      prgSwap <= strb.wdata[6];
      chrSwap <= strb.wdata[7];
    end
  end

  // mirroring register
  always_ff @(posedge clk) begin
    if (rst)
      mirror <= MIR_VERT;
    else if (strb.mirrWr)
      mirror <= mirror_e'(strb.wdata[1:0]);
  end

  // program bank registers, indices 6..9
  genvar gp;
  generate
    for (gp = 0; gp < 4; gp++) begin : g_prg
      localparam logic [PRG_BW-1:0] RST_VAL =
        (gp == 0) ? PRG_BW'(0) : (gp == 1) ? PRG_BW'(1) :
        (gp == 2) ? PRG_PREV : PRG_LAST;
      always_ff @(posedge clk) begin
        if (rst)
          prgRegs[gp] <= RST_VAL;
        else if (strb.dataWr && ctrlIdx == 4'(6 + gp))
          prgRegs[gp] <= strb.wdata[PRG_BW-1:0];
      end
    end
  endgenerate

  // pattern banks 4..7, indices 2..5
  genvar gc;
  generate
    for (gc = 4; gc < 8; gc++) begin : g_chr_hi
      always_ff @(posedge clk) begin
        if (rst)
          chrRegs[gc] <= CHR_W'(gc);
        else if (strb.dataWr && ctrlIdx == 4'(gc - 2))
          chrRegs[gc] <= chrVal;
      end
    end
  endgenerate

  // pattern banks 0..3: pairs with a separately loadable odd half
  generate
    for (gc = 0; gc < 2; gc++) begin : g_chr_pair
      localparam logic [3:0] PAIR_IDX = (gc == 0) ? IDX_CPAIR0 : IDX_CPAIR1;
      localparam logic [3:0] ODD_IDX  = (gc == 0) ? IDX_CODD1  : IDX_CODD3;
      always_ff @(posedge clk) begin
        if (rst) begin
          chrRegs[2*gc]   <= CHR_W'(2*gc);
          chrRegs[2*gc+1] <= CHR_W'(2*gc+1);
        end else if (strb.dataWr) begin
          if (ctrlIdx == PAIR_IDX) begin
            chrRegs[2*gc]   <= chrVal;
            chrRegs[2*gc+1] <= chrNext;
          end else if (ctrlIdx == ODD_IDX) begin
            chrRegs[2*gc+1] <= chrVal;
          end
        end
      end
    end
  endgenerate

  // R4: unused indices leave every bank register alone
  a_r4_ignored_idx: assert property (@(posedge clk) disable iff (rst)
    (strb.dataWr && ctrlIdx >= 4'hC) |=> ($stable(prgRegs) && $stable(chrRegs)));

  // R2: index 0 keeps bank 1 one above bank 0
  a_r2_pair_follow: assert property (@(posedge clk) disable iff (rst)
    (strb.dataWr && ctrlIdx == IDX_CPAIR0) |=> (chrRegs[1] == chrRegs[0] + CHR_W'(1)));

  // R7: mirroring changes only after a mirroring write
  a_r7_mirror_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.mirrWr |=> $stable(mirror));

endmodule

// File: rtl/xbank_window.sv
module xbank_window
  import xbank_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_W     = 8,
  parameter bit CHR_RAM   = 1'b0,
  localparam int PRG_BW   = $clog2(PRG_BANKS)
)(
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             cpuWin,
  input  logic [2:0]             ppuWin,
  input  logic                   prgSwap,
  input  logic                   chrSwap,
  input  logic [3:0][PRG_BW-1:0] prgRegs,
  input  logic [7:0][CHR_W-1:0]  chrRegs,
  output logic [PRG_BW-1:0]      prgBank,
  output logic [CHR_W-1:0]       chrBank
);

  logic [1:0]       prgSel;
  logic [2:0]       chrSel;
  logic [CHR_W-1:0] chrRaw;

  // windows 0 and 2 trade places when prgSwap is set
  assign prgSel  = (prgSwap && !cpuWin[0]) ? {~cpuWin[1], cpuWin[0]} : cpuWin;
  assign prgBank = prgRegs[prgSel];

  // the two 4 KB halves trade places when chrSwap is set
  assign chrSel = {ppuWin[2] ^ chrSwap, ppuWin[1:0]};
  assign chrRaw = chrRegs[chrSel];

  generate
    if (CHR_RAM) begin : g_ram
      assign chrBank = {{(CHR_W-3){1'b0}}, chrRaw[2:0]};
    end else begin : g_rom
      assign chrBank = chrRaw;
    end
  endgenerate

  // R5: the top program window is never reordered
  a_r5_fixed_top: assert property (@(posedge clk) disable iff (rst)
    (cpuWin == 2'd3) |-> (prgBank == prgRegs[3]));

  // R10: outputs move only when registers or address move
  a_r10_prg_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(cpuWin) && $stable(prgSwap) && $stable(prgRegs)) |-> $stable(prgBank));

  a_r10_chr_hold: assert property (@(posedge clk) disable iff (rst)
    ($stable(ppuWin) && $stable(chrSwap) && $stable(chrRegs)) |-> $stable(chrBank));

endmodule

// File: rtl/xbank_mapper.sv
module xbank_mapper
  import xbank_pkg::*;
#(
  parameter int PRG_BANKS = 32,
  parameter int CHR_W     = 8,
  parameter bit CHR_RAM   = 1'b0,
  localparam int PRG_BW   = $clog2(PRG_BANKS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic [15:0]       cpuAddr,
  input  logic [7:0]        cpuData,
  input  logic              cpuWrite,
  input  logic [13:0]       ppuAddr,
  output logic [PRG_BW-1:0] prgBank,
  output logic [CHR_W-1:0]  chrBank,
  output logic [1:0]        mirrorMode
);

  wrStrobe_t               strb;
  logic                    prgSwap;
  logic                    chrSwap;
  logic [3:0][PRG_BW-1:0]  prgRegs;
  logic [7:0][CHR_W-1:0]   chrRegs;
  mirror_e                 mirror;
  logic                    unusedBits;

  assign unusedBits = ^{cpuAddr[12:1], ppuAddr[13], ppuAddr[9:0]};
  assign mirrorMode = mirror;

  xbank_decode u_decode (
    .clk     (clk),
    .rst     (rst),
    .addrTop (cpuAddr[15:13]),
    .addrLsb (cpuAddr[0]),
    .wrData  (cpuData),
    .wrEn    (cpuWrite),
    .strb    (strb)
  );

  xbank_regs #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_W     (CHR_W)
  ) u_regs (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .prgSwap (prgSwap),
    .chrSwap (chrSwap),
    .prgRegs (prgRegs),
    .chrRegs (chrRegs),
    .mirror  (mirror)
  );

  xbank_window #(
    .PRG_BANKS (PRG_BANKS),
    .CHR_W     (CHR_W),
    .CHR_RAM   (CHR_RAM)
  ) u_window (
    .clk     (clk),
    .rst     (rst),
    .cpuWin  (cpuAddr[14:13]),
    .ppuWin  (ppuAddr[12:10]),
    .prgSwap (prgSwap),
    .chrSwap (chrSwap),
    .prgRegs (prgRegs),
    .chrRegs (chrRegs),
    .prgBank (prgBank),
    .chrBank (chrBank)
  );

endmodule

// File: tb/xbank_mapper_tb.sv
module xbank_mapper_tb;

  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] cpuAddr;
  logic [7:0]  cpuData;
  logic        cpuWrite;
  logic [13:0] ppuAddr;
  logic [4:0]  prgBank, prgBankR;
  logic [7:0]  chrBank, chrBankR;
  logic [1:0]  mirrorMode, mirrorModeR;

  int tests = 0;
  int fails = 0;

  logic [7:0] mPrg [4];
  logic [7:0] mChr [8];
  logic [7:0] mCtrl;
  logic [1:0] mMir;

  always #4 clk = ~clk;

  xbank_mapper #(.PRG_BANKS(32), .CHR_W(8), .CHR_RAM(1'b0)) u_dut (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWrite(cpuWrite),
    .ppuAddr(ppuAddr), .prgBank(prgBank), .chrBank(chrBank), .mirrorMode(mirrorMode));

  xbank_mapper #(.PRG_BANKS(32), .CHR_W(8), .CHR_RAM(1'b1)) u_ram (
    .clk(clk), .rst(rst), .cpuAddr(cpuAddr), .cpuData(cpuData), .cpuWrite(cpuWrite),
    .ppuAddr(ppuAddr), .prgBank(prgBankR), .chrBank(chrBankR), .mirrorMode(mirrorModeR));

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expPrg(int w);
    if (mCtrl[6] && w == 0) return int'(mPrg[2]);
    if (mCtrl[6] && w == 2) return int'(mPrg[0]);
    return int'(mPrg[w]);
  endfunction

  function automatic int expChr(int w);
    return mCtrl[7] ? int'(mChr[w ^ 4]) : int'(mChr[w]);
  endfunction

  task automatic modelWrite(logic [15:0] a, logic [7:0] d);
    if (a[15]) begin
      case ({a[14:13], a[0]})
        3'b000: mCtrl = d;
        3'b001: begin
          case (mCtrl[3:0])
            4'h0: begin mChr[0] = d; mChr[1] = d + 8'd1; end
            4'h1: begin mChr[2] = d; mChr[3] = d + 8'd1; end
            4'h2, 4'h3, 4'h4, 4'h5: mChr[mCtrl[3:0] + 2] = d;
            4'h6, 4'h7, 4'h8, 4'h9: mPrg[mCtrl[3:0] - 6] = d & 8'd31;
            4'hA: mChr[1] = d;
            4'hB: mChr[3] = d;
            default: ;
          endcase
        end
        3'b010: mMir = d[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuAddr  = a;
    cpuData  = d;
    cpuWrite = 1'b1;
    @(negedge clk);
    cpuWrite = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic checkAll(string req);
    for (int w = 0; w < 4; w++) begin
      cpuAddr = 16'h8000 | 16'(w << 13) | 16'h0155;
      #1;
      check({req, " prg"}, int'(prgBank), expPrg(w));
      check({req, " prg R9 variant"}, int'(prgBankR), expPrg(w));
    end
    for (int w = 0; w < 8; w++) begin
      ppuAddr = 14'(w << 10) | 14'h02A9;
      #1;
      check({req, " chr"}, int'(chrBank), expChr(w));
      check({req, " chr R9 mask"}, int'(chrBankR), expChr(w) & 7);
    end
    check({req, " mirror"}, int'(mirrorMode), int'(mMir));
    check({req, " mirror R9 variant"}, int'(mirrorModeR), int'(mMir));
  endtask

  initial begin
    #(8 * 150000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; cpuWrite = 1'b0; cpuAddr = 16'h0000; cpuData = 8'h00; ppuAddr = 14'h0;
    mPrg[0] = 8'd0; mPrg[1] = 8'd1; mPrg[2] = 8'd30; mPrg[3] = 8'd31;
    for (int i = 0; i < 8; i++) mChr[i] = 8'(i);
    mCtrl = 8'h00; mMir = 2'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    checkAll("R8 reset");

    // index sweep with alias addresses inside the even/odd register pair
    for (int idx = 0; idx < 16; idx++) begin
      wr(16'h8000 | 16'(idx << 4), 8'(idx));
      wr(16'h8001 | 16'(idx << 5), 8'(idx * 53 + 29));
      if (idx < 2)       checkAll("R2 pair R10");
      else if (idx < 12) checkAll("R3 index R10");
      else               checkAll("R4 ignored");
    end

    // control bit 6 and 7 combinations
    for (int c = 0; c < 4; c++) begin
      wr(16'h8000, {2'(c), 6'h0C});
      checkAll("R5 R6 order");
    end

    // pair wrap and program truncation
    wr(16'h8000, 8'h00); wr(16'h8001, 8'hFF); checkAll("R2 wrap");
    wr(16'h8000, 8'h01); wr(16'h8003, 8'hFF); checkAll("R2 wrap odd");
    wr(16'h8000, 8'h06); wr(16'h8001, 8'hE5); checkAll("R3 truncate");
    wr(16'h8000, 8'hC9); wr(16'h9FFF, 8'h3B); checkAll("R3 R5 R6 mixed");

    // mirroring codes, including upper data bits
    begin
      logic [7:0] mv [6];
      mv[0] = 8'h00; mv[1] = 8'h01; mv[2] = 8'h02; mv[3] = 8'h03; mv[4] = 8'h7E; mv[5] = 8'hFD;
      for (int k = 0; k < 6; k++) begin
        wr(16'hA000 | 16'(k << 3), mv[k]);
        checkAll("R7 mirror");
      end
    end

    // writes outside the decoded registers
    wr(16'h8000, 8'h07);
    wr(16'h0001, 8'h44); checkAll("R1 low half");
    wr(16'h7FFF, 8'h45); checkAll("R1 below range");
    wr(16'hA001, 8'h02); checkAll("R1 odd mirror");
    wr(16'hC000, 8'h47); checkAll("R1 C region");
    wr(16'hE001, 8'h48); checkAll("R1 E region");
    wr(16'h0000, 8'hFF); checkAll("R1 low even");

    // visibility relative to the capturing edge
    wr(16'h8000, 8'h06);
    @(negedge clk);
    cpuAddr = 16'h8001; cpuData = 8'h11; cpuWrite = 1'b1;
    #1;
    check("R10 before edge", int'(prgBank), expPrg(0));
    @(negedge clk);
    cpuWrite = 1'b0;
    modelWrite(16'h8001, 8'h11);
    #1;
    check("R10 after edge", int'(prgBank), 17);
    checkAll("R10 settle");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule